// File: doc/BRIEF.md
# SWD Register Access Sequencer

This block sits between a client that wants whole register accesses on a Serial Wire Debug link and a lower engine that carries out single SWD transfers. The client issues one command: a read or a write, aimed at the debug port (DP) or at the access port (AP) that is currently selected. The block runs the engine transfers that the command needs and reports one final status. When the command ends, it also reports the data read.

AP reads on SWD are posted: the data an AP read returns belongs to the AP read before it. The sequencer hides this. It issues the AP read and discards the value that comes back. It then reads the DP read-buffer register, which returns the pending result without starting a new AP access. DP reads return their data at once and need no second transfer.

A transfer acknowledged with WAIT is issued again. The number of retries is bounded by a runtime limit, and running past the limit ends the command with a timeout. A FAULT acknowledge ends the command with a fault, and so does any acknowledge code the block does not recognise. An AP write can ask for completion polling: the block then reads the memory-AP control/status register (through the read buffer) until its transfer-in-progress flag reads clear. This polling loop is bounded by a second runtime limit.

The states are:
- `S_IDLE`: waits for a command.
- `S_MAIN_SEND` / `S_MAIN_WAIT`: the client's own transfer.
- `S_FETCH_SEND` / `S_FETCH_WAIT`: the read-buffer fetch after an AP read.
- `S_POLL_SEND` / `S_POLL_WAIT`: the AP read of the control/status register.
- `S_PFETCH_SEND` / `S_PFETCH_WAIT`: the read-buffer fetch of that poll value.
- `S_FINISH`: one-cycle completion.

The transitions are:
- Every SEND state moves to its WAIT state.
- A WAIT state that sees a WAIT acknowledge below the limit moves back to its SEND state.
- An OK acknowledge moves on to the next phase, or to `S_FINISH`.
- A FAULT, or WAIT at the limit, moves to `S_FINISH`.
- `S_FINISH` moves to `S_IDLE`.

Top module: `swd_access_seq`

## Requirements
- R1: After reset, `busy`, `done` and `eng_req` are 0.
- R2: A DP read makes exactly one engine transfer, a read with `eng_ap`=0 at the client address. It completes with status 0 (OK) and `rdata` equal to the data of that transfer.
- R3: An AP read makes an AP read at the client address, then a DP read at address code 2'b11 (the read buffer). It completes OK with `rdata` equal to the read-buffer data. `cmd_addr`/`eng_addr` carry register offset bits [3:2].
- R4: A DP write, or an AP write without `cmd_poll`, makes one write transfer carrying `cmd_wdata`. It completes OK with `rdata` = 0.
- R5: An acknowledge of 3'b010 (WAIT) re-issues the same transfer. Up to `cfg_retry_limit` consecutive WAITs on one transfer are tolerated. One more ends the command with status 2 (timeout). The retry count restarts for each new transfer.
- R6: An acknowledge of 3'b100 (FAULT), or any code other than 3'b001 (OK) and 3'b010, ends the command with status 1 (fault). No further transfer is made.
- R7: An AP write with `cmd_poll`=1 is followed by an AP read at address code 2'b00 (control/status) and a read-buffer fetch. This pair repeats while bit `BUSY_BIT` (default 7) of the fetched value is 1, and the command completes OK once that bit reads 0.
- R8: If the poll value shows the flag set `cfg_poll_limit`+1 times in a row, the command ends with status 2 (timeout).
- R9: `cmd_valid` is ignored while `busy` is 1.
- R10: `done` is a one-cycle pulse with `status`/`rdata` valid, after which `busy` is 0. `eng_req` is a one-cycle pulse per transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_ap | input | 1 | 1 = access port, 0 = debug port |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_poll | input | 1 | On AP writes, poll transfer-in-progress flag before completing |
| cmd_addr | input | 2 | Register offset bits [3:2] |
| cmd_wdata | input | DATA_W | Write data |
| cfg_retry_limit | input | CNT_W | Maximum WAIT retries per transfer |
| cfg_poll_limit | input | CNT_W | Maximum re-polls of the busy flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| status | output | 2 | 0 OK, 1 fault, 2 timeout |
| rdata | output | DATA_W | Read result (0 for writes) |
| eng_req | output | 1 | Transfer request pulse to the engine |
| eng_ap | output | 1 | Transfer targets AP |
| eng_write | output | 1 | Transfer is a write |
| eng_addr | output | 2 | Transfer register offset bits [3:2] |
| eng_wdata | output | DATA_W | Transfer write data |
| eng_done | input | 1 | Engine transfer finished, ack and data valid |
| eng_ack | input | 3 | Acknowledge code |
| eng_rdata | input | DATA_W | Data returned by the transfer |

## Verification
The bench builds the block with `CNT_W`=4 and the default 32-bit data width and busy-flag position. At run time it sets the retry limit to 3 and the poll limit to 2, so both the last tolerated WAIT and the first excess WAIT are reached within a few transfers. It also sets the retry limit to 0 to show that a single WAIT then times out. Its engine model returns AP data one read late and counts down a busy flag in the control/status register. A sequencer that skips the read-buffer fetch, or that mis-counts polls or retries, therefore gives wrong data or wrong transfer counts.

// File: rtl/swdseq_pkg.sv
package swdseq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MAIN_SEND,
        S_MAIN_WAIT,
        S_FETCH_SEND,
        S_FETCH_WAIT,
        S_POLL_SEND,
        S_POLL_WAIT,
        S_PFETCH_SEND,
        S_PFETCH_WAIT,
        S_FINISH
    } seq_state_t;

    typedef enum logic [1:0] {
        AK_OK,
        AK_WAIT,
        AK_FAIL
    } ack_kind_t;

    localparam logic [1:0] ST_OK      = 2'd0;
    localparam logic [1:0] ST_FAULT   = 2'd1;
    localparam logic [1:0] ST_TIMEOUT = 2'd2;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [1:0] ADDR_RDBUF = 2'b11;
    localparam logic [1:0] ADDR_CTRL  = 2'b00;

endpackage

// File: rtl/swdseq_ack_decode.sv
module swdseq_ack_decode
    import swdseq_pkg::*;
(
    input  logic [2:0] ack,
    output ack_kind_t  kind
);

    always_comb begin
        unique case (ack)
            ACK_OK:   kind = AK_OK;
            ACK_WAIT: kind = AK_WAIT;
            default:  kind = AK_FAIL;
        endcase
    end

endmodule

// File: rtl/swdseq_bound_cnt.sv
module swdseq_bound_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] limit,
    output logic         at_limit
);

    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && (cnt != '1)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign at_limit = (cnt == limit);

    // R5 / R8: the sequencer never counts past the programmed bound
    p_inc_below_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_limit);

endmodule

// File: rtl/swd_access_seq.sv
module swd_access_seq
    import swdseq_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int CNT_W    = 8,
    parameter int BUSY_BIT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              cmd_ap,
    input  logic              cmd_write,
    input  logic              cmd_poll,
    input  logic [1:0]        cmd_addr,
    input  logic [DATA_W-1:0] cmd_wdata,
    input  logic [CNT_W-1:0]  cfg_retry_limit,
    input  logic [CNT_W-1:0]  cfg_poll_limit,
    output logic              busy,
    output logic              done,
    output logic [1:0]        status,
    output logic [DATA_W-1:0] rdata,
    output logic              eng_req,
    output logic              eng_ap,
    output logic              eng_write,
    output logic [1:0]        eng_addr,
    output logic [DATA_W-1:0] eng_wdata,
    input  logic              eng_done,
    input  logic [2:0]        eng_ack,
    input  logic [DATA_W-1:0] eng_rdata
);

    seq_state_t        state, nxt;
    ack_kind_t         ack_kind;

    logic              c_ap, c_wr, c_poll;
    logic [1:0]        c_addr;
    logic [DATA_W-1:0] c_wdata;

    logic [1:0]        res_status;
    logic [DATA_W-1:0] res_data;

    logic              fin_set;
    logic [1:0]        fin_status;
    logic [DATA_W-1:0] fin_data;
    logic              in_wait;
    logic              wait_inc, wait_clr, wait_at_limit;
    logic              poll_inc, poll_clr, poll_at_limit;

    function automatic seq_state_t resend(input seq_state_t s);
        case (s)
            S_MAIN_WAIT:   return S_MAIN_SEND;
            S_FETCH_WAIT:  return S_FETCH_SEND;
            S_POLL_WAIT:   return S_POLL_SEND;
            S_PFETCH_WAIT: return S_PFETCH_SEND;
            default:       return S_IDLE;
        endcase
    endfunction

    swdseq_ack_decode u_ack (
        .ack  (eng_ack),
        .kind (ack_kind)
    );

    swdseq_bound_cnt #(.W(CNT_W)) u_wait_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wait_clr),
        .inc      (wait_inc),
        .limit    (cfg_retry_limit),
        .at_limit (wait_at_limit)
    );

    swdseq_bound_cnt #(.W(CNT_W)) u_poll_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (poll_clr),
        .inc      (poll_inc),
        .limit    (cfg_poll_limit),
        .at_limit (poll_at_limit)
    );

    assign in_wait = (state == S_MAIN_WAIT) || (state == S_FETCH_WAIT) ||
                     (state == S_POLL_WAIT) || (state == S_PFETCH_WAIT);

    // next-state and completion decision
    always_comb begin
        nxt        = state;
        fin_set    = 1'b0;
        fin_status = ST_OK;
        fin_data   = '0;
        wait_inc   = 1'b0;
        poll_inc   = 1'b0;
        wait_clr   = (state == S_IDLE) || (in_wait && eng_done && ack_kind == AK_OK);
        poll_clr   = (state == S_IDLE);
        unique case (state)
            S_IDLE:        if (cmd_valid) nxt = S_MAIN_SEND;
            S_MAIN_SEND:   nxt = S_MAIN_WAIT;
            S_FETCH_SEND:  nxt = S_FETCH_WAIT;
            S_POLL_SEND:   nxt = S_POLL_WAIT;
            S_PFETCH_SEND: nxt = S_PFETCH_WAIT;
            S_MAIN_WAIT, S_FETCH_WAIT, S_POLL_WAIT, S_PFETCH_WAIT: begin
                if (eng_done) begin
                    unique case (ack_kind)
                        AK_WAIT: begin
                            if (wait_at_limit) begin
                                nxt        = S_FINISH;
                                fin_set    = 1'b1;
                                fin_status = ST_TIMEOUT;
                            end else begin
                                wait_inc = 1'b1;
                                nxt      = resend(state);
                            end
                        end
                        AK_OK: begin
                            case (state)
                                S_MAIN_WAIT: begin
                                    if (c_ap && !c_wr) begin
                                        nxt = S_FETCH_SEND;
                                    end else if (c_ap && c_wr && c_poll) begin
                                        nxt = S_POLL_SEND;
                                    end else begin
                                        nxt      = S_FINISH;
                                        fin_set  = 1'b1;
                                        fin_data = c_wr ? '0 : eng_rdata;
                                    end
                                end
                                S_FETCH_WAIT: begin
                                    nxt      = S_FINISH;
                                    fin_set  = 1'b1;
                                    fin_data = eng_rdata;
                                end
                                S_POLL_WAIT: nxt = S_PFETCH_SEND;
                                default: begin
                                    if (eng_rdata[BUSY_BIT]) begin
                                        if (poll_at_limit) begin
                                            nxt        = S_FINISH;
                                            fin_set    = 1'b1;
                                            fin_status = ST_TIMEOUT;
                                        end else begin
                                            poll_inc = 1'b1;
                                            nxt      = S_POLL_SEND;
                                        end
                                    end else begin
                                        nxt     = S_FINISH;
                                        fin_set = 1'b1;
                                    end
                                end
                            endcase
                        end
                        default: begin
                            nxt        = S_FINISH;
                            fin_set    = 1'b1;
                            fin_status = ST_FAULT;
                        end
                    endcase
                end
            end
            S_FINISH: nxt = S_IDLE;
            default:  nxt = S_IDLE;
        endcase
    end

    // state register, command latch, result latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state      <= S_IDLE;
            c_ap       <= 1'b0;
            c_wr       <= 1'b0;
            c_poll     <= 1'b0;
            c_addr     <= '0;
            c_wdata    <= '0;
            res_status <= ST_OK;
            res_data   <= '0;
        end else begin
            state <= nxt;
            if (state == S_IDLE && cmd_valid) begin
                c_ap    <= cmd_ap;
                c_wr    <= cmd_write;
                c_poll  <= cmd_poll;
                c_addr  <= cmd_addr;
                c_wdata <= cmd_wdata;
            end
            if (fin_set) begin
                res_status <= fin_status;
                res_data   <= fin_data;
            end
        end
    end

    // outputs
    always_comb begin
        busy      = (state != S_IDLE);
        done      = (state == S_FINISH);
        status    = res_status;
        rdata     = res_data;
        eng_wdata = c_wdata;
        eng_req   = 1'b0;
        eng_ap    = 1'b0;
        eng_write = 1'b0;
        eng_addr  = ADDR_RDBUF;
        unique case (state)
            S_MAIN_SEND, S_MAIN_WAIT: begin
                eng_req   = (state == S_MAIN_SEND);
                eng_ap    = c_ap;
                eng_write = c_wr;
                eng_addr  = c_addr;
            end
            S_FETCH_SEND, S_FETCH_WAIT, S_PFETCH_SEND, S_PFETCH_WAIT: begin
                eng_req = (state == S_FETCH_SEND) || (state == S_PFETCH_SEND);
            end
            S_POLL_SEND, S_POLL_WAIT: begin
                eng_req  = (state == S_POLL_SEND);
                eng_ap   = 1'b1;
                eng_addr = ADDR_CTRL;
            end
            default: ;
        endcase
    end

    // R10: one request pulse per transfer
    p_req_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req |=> !eng_req);

    // R10: completion is a single cycle and returns to idle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    // R3: an accepted AP read is followed by the read-buffer fetch
    p_fetch_after_apread_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MAIN_WAIT && eng_done && eng_ack == ACK_OK && c_ap && !c_wr)
        |=> (eng_req && !eng_ap && !eng_write && eng_addr == ADDR_RDBUF));

    // R5: a WAIT below the limit re-issues the same transfer
    p_wait_retry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && eng_done && eng_ack == ACK_WAIT && !wait_at_limit)
        |=> (eng_req && $stable(eng_addr) && $stable(eng_ap) && $stable(eng_write)));

    // R5: a WAIT at the limit ends in timeout
    p_wait_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && eng_done && eng_ack == ACK_WAIT && wait_at_limit)
        |=> (done && status == ST_TIMEOUT));

    // R6: FAULT ends the command
    p_fault_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wait && eng_done && eng_ack == ACK_FAULT)
        |=> (done && status == ST_FAULT && !eng_req));

    // R9: the latched command does not change while busy
    p_hold_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable({c_ap, c_wr, c_poll, c_addr, c_wdata}));

endmodule

// File: tb/test_swd_access_seq.sv
module test_swd_access_seq;

    localparam int DATA_W = 32;
    localparam int CNT_W  = 4;
    localparam logic [2:0] A_OK = 3'b001, A_WAIT = 3'b010, A_FLT = 3'b100;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0, cmd_ap = 1'b0, cmd_write = 1'b0, cmd_poll = 1'b0;
    logic [1:0]        cmd_addr = '0;
    logic [DATA_W-1:0] cmd_wdata = '0;
    logic [CNT_W-1:0]  cfg_retry_limit = 4'd3, cfg_poll_limit = 4'd2;
    logic              busy, done, eng_req, eng_ap, eng_write;
    logic [1:0]        status, eng_addr;
    logic [DATA_W-1:0] rdata, eng_wdata;
    logic              eng_done = 1'b0;
    logic [2:0]        eng_ack = A_OK;
    logic [DATA_W-1:0] eng_rdata = '0;

    swd_access_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) i_swd_access_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ap(cmd_ap),
        .cmd_write(cmd_write), .cmd_poll(cmd_poll), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cfg_retry_limit(cfg_retry_limit),
        .cfg_poll_limit(cfg_poll_limit), .busy(busy), .done(done),
        .status(status), .rdata(rdata), .eng_req(eng_req), .eng_ap(eng_ap),
        .eng_write(eng_write), .eng_addr(eng_addr), .eng_wdata(eng_wdata),
        .eng_done(eng_done), .eng_ack(eng_ack), .eng_rdata(eng_rdata)
    );

    always #5 clk = ~clk;

    int n_chk = 0, n_fail = 0;

    // target model
    logic [DATA_W-1:0] dp_reg [4];
    logic [DATA_W-1:0] ap_reg [4];
    logic [DATA_W-1:0] ap_pend = '0;
    int                csw_busy = 0;
    logic [2:0]        script [16];
    int                xfer_n = 0;
    logic              log_ap [32];
    logic              log_wr [32];
    logic [1:0]        log_addr [32];

    int                cd = 0;
    logic [2:0]        r_ack = A_OK;
    logic [DATA_W-1:0] r_data = '0;

    function automatic logic [DATA_W-1:0] ap_value(input logic [1:0] a);
        if (a == 2'd0) return ap_reg[0] | ((csw_busy > 0) ? 32'h80 : 32'h0);
        return ap_reg[a];
    endfunction

    task automatic serve(input logic ap, input logic wr, input logic [1:0] a,
                         input logic [DATA_W-1:0] wd);
        r_ack  = (xfer_n < 16) ? script[xfer_n] : A_OK;
        r_data = 32'hDEAD_0000 + DATA_W'(xfer_n);
        if (xfer_n < 32) begin
            log_ap[xfer_n] = ap; log_wr[xfer_n] = wr; log_addr[xfer_n] = a;
        end
        xfer_n++;
        if (r_ack == A_OK) begin
            if (ap && !wr) begin
                r_data  = ap_pend;
                ap_pend = ap_value(a);
                if (a == 2'd0 && csw_busy > 0) csw_busy--;
            end else if (ap && wr) begin
                if (a != 2'd0) ap_reg[a] = wd;
            end else if (!wr) begin
                r_data = (a == 2'd3) ? ap_pend : dp_reg[a];
            end else if (a != 2'd3) begin
                dp_reg[a] = wd;
            end
        end
    endtask

    initial begin
        forever begin
            @(negedge clk);
            eng_done = 1'b0;
            if (cd > 0) begin
                cd--;
                if (cd == 0) begin
                    eng_done  = 1'b1;
                    eng_ack   = r_ack;
                    eng_rdata = r_data;
                end
            end
            if (eng_req) begin
                serve(eng_ap, eng_write, eng_addr, eng_wdata);
                cd = 1 + int'($urandom % 3);
            end
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    logic [1:0]        got_st;
    logic [DATA_W-1:0] got_d;
    int                got_n;

    task automatic run_cmd(input logic ap, input logic wr, input logic poll,
                           input logic [1:0] a, input logic [DATA_W-1:0] wd,
                           input logic disturb);
        int guard;
        @(negedge clk);
        xfer_n = 0;
        cmd_valid = 1'b1; cmd_ap = ap; cmd_write = wr; cmd_poll = poll;
        cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0;
        guard = 0;
        while (!done && guard < 2000) begin
            if (disturb && guard == 1) begin
                cmd_valid = 1'b1; cmd_ap = ~ap; cmd_write = ~wr; cmd_addr = ~a;
            end else begin
                cmd_valid = 1'b0;
            end
            @(negedge clk);
            guard++;
        end
        cmd_valid = 1'b0;
        if (guard >= 2000) chk("watchdog command hang", 1, 0);
        got_st = status; got_d = rdata; got_n = xfer_n;
        @(negedge clk);
        chk("R10 done one cycle", {done, busy}, 2'b00);
        chk("R10 status held", status, got_st);
        for (int i = 0; i < 16; i++) script[i] = A_OK;
    endtask

    // expected number of transfers for a clean command
    function automatic int exp_xfers(input logic ap, input logic wr);
        return (ap && !wr) ? 2 : 1;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=expired expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < 16; i++) script[i] = A_OK;
        for (int i = 0; i < 4; i++) begin
            dp_reg[i] = 32'h1000_0000 + 32'(i * 32'h111);
            ap_reg[i] = 32'hA000_0000 + 32'(i * 32'h2222);
        end
        ap_reg[0] = 32'h0000_0012;
        dp_reg[3] = 32'h0;
        repeat (3) @(negedge clk);
        chk("R1 reset busy/done/req", {busy, done, eng_req}, 3'b000);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 idle after reset", {busy, done, eng_req}, 3'b000);

        // R2 DP read
        run_cmd(0, 0, 0, 2'd1, '0, 0);
        chk("R2 status", got_st, 0);
        chk("R2 data", got_d, dp_reg[1]);
        chk("R2 xfers", got_n, 1);
        chk("R2 kind", {log_ap[0], log_wr[0], log_addr[0]}, {1'b0, 1'b0, 2'd1});

        // R3 AP reads, back to back
        begin
            logic [DATA_W-1:0] e2, e3;
            e2 = ap_reg[2]; e3 = ap_reg[3];
            run_cmd(1, 0, 0, 2'd2, '0, 0);
            chk("R3 data first", got_d, e2);
            chk("R3 xfers", got_n, 2);
            chk("R3 seq0 AP read addr", {log_ap[0], log_wr[0], log_addr[0]}, {1'b1, 1'b0, 2'd2});
            chk("R3 seq1 RDBUF fetch", {log_ap[1], log_wr[1], log_addr[1]}, {1'b0, 1'b0, 2'd3});
            run_cmd(1, 0, 0, 2'd3, '0, 0);
            chk("R3 data second", got_d, e3);
        end

        // R4 writes
        run_cmd(0, 1, 0, 2'd2, 32'h55AA_1234, 0);
        chk("R4 DP write status", got_st, 0);
        chk("R4 DP write rdata", got_d, 0);
        chk("R4 DP write xfers", got_n, 1);
        run_cmd(0, 0, 0, 2'd2, '0, 0);
        chk("R4 DP write landed", got_d, 32'h55AA_1234);
        run_cmd(1, 1, 0, 2'd1, 32'hCAFE_0001, 0);
        chk("R4 AP write xfers", got_n, 1);
        run_cmd(1, 0, 0, 2'd1, '0, 0);
        chk("R4 AP write landed", got_d, 32'hCAFE_0001);

        // R5 WAIT retries, limit 3
        script[0] = A_WAIT; script[1] = A_WAIT; script[2] = A_WAIT;
        run_cmd(0, 0, 0, 2'd0, '0, 0);
        chk("R5 three waits ok status", got_st, 0);
        chk("R5 three waits data", got_d, dp_reg[0]);
        chk("R5 three waits xfers", got_n, 4);
        for (int i = 0; i < 4; i++) script[i] = A_WAIT;
        run_cmd(0, 0, 0, 2'd0, '0, 0);
        chk("R5 four waits timeout", got_st, 2);
        chk("R5 four waits xfers", got_n, 4);
        script[1] = A_WAIT; script[2] = A_WAIT; script[3] = A_WAIT;
        begin
            logic [DATA_W-1:0] e;
            e = ap_reg[2];
            run_cmd(1, 0, 0, 2'd2, '0, 0);
            chk("R5 waits on fetch data", got_d, e);
            chk("R5 waits on fetch xfers", got_n, 5);
            chk("R5 retried fetch addr", {log_ap[4], log_addr[4]}, {1'b0, 2'd3});
        end
        script[0] = A_WAIT; script[1] = A_WAIT; script[3] = A_WAIT;
        script[4] = A_WAIT; script[5] = A_WAIT;
        run_cmd(1, 0, 0, 2'd1, '0, 0);
        chk("R5 count restarts per transfer", {got_st, 32'(got_n)}, {2'd0, 32'd7});
        cfg_retry_limit = 4'd0;
        script[0] = A_WAIT;
        run_cmd(0, 0, 0, 2'd1, '0, 0);
        chk("R5 limit zero timeout", {got_st, 32'(got_n)}, {2'd2, 32'd1});
        cfg_retry_limit = 4'd3;

        // R6 fault
        script[0] = A_FLT;
        run_cmd(0, 0, 0, 2'd1, '0, 0);
        chk("R6 fault status", got_st, 1);
        chk("R6 fault xfers", got_n, 1);
        script[1] = A_FLT;
        run_cmd(1, 0, 0, 2'd2, '0, 0);
        chk("R6 fault on fetch", {got_st, 32'(got_n)}, {2'd1, 32'd2});
        script[0] = 3'b111;
        run_cmd(1, 1, 0, 2'd2, 32'h1, 0);
        chk("R6 invalid ack fault", {got_st, 32'(got_n)}, {2'd1, 32'd1});
        repeat (4) @(negedge clk);
        chk("R6 no further transfer", xfer_n, 1);

        // R7 / R8 polling
        csw_busy = 0;
        run_cmd(1, 1, 1, 2'd3, 32'h7777_0000, 0);
        chk("R7 poll idle flag xfers", {got_st, 32'(got_n)}, {2'd0, 32'd3});
        chk("R7 poll reads CSW", {log_ap[1], log_wr[1], log_addr[1]}, {1'b1, 1'b0, 2'd0});
        chk("R7 poll fetch", {log_ap[2], log_addr[2]}, {1'b0, 2'd3});
        csw_busy = 2;
        run_cmd(1, 1, 1, 2'd3, 32'h7777_0001, 0);
        chk("R7 poll two busy", {got_st, 32'(got_n)}, {2'd0, 32'd7});
        chk("R7 rdata zero", got_d, 0);
        csw_busy = 3;
        run_cmd(1, 1, 1, 2'd3, 32'h7777_0002, 0);
        chk("R8 poll timeout", {got_st, 32'(got_n)}, {2'd2, 32'd7});

        // R9 ignore commands while busy
        run_cmd(0, 0, 0, 2'd1, '0, 1);
        chk("R9 data unaffected", got_d, dp_reg[1]);
        chk("R9 single transfer", got_n, 1);
        repeat (5) @(negedge clk);
        chk("R9 nothing launched after", {32'(xfer_n), 1'b0 + busy}, {32'd1, 1'b0});

        // random mix, R2 R3 R4 R5
        for (int it = 0; it < 200; it++) begin
            int kind, nw;
            logic ap, wr;
            logic [1:0] a;
            logic [DATA_W-1:0] wd, e;
            kind = int'($urandom % 4);
            ap = kind[1]; wr = kind[0];
            a  = ap ? 2'(1 + $urandom % 3) : 2'($urandom % 3);
            wd = $urandom;
            nw = int'($urandom % 4);
            for (int k = 0; k < nw; k++) script[k] = A_WAIT;
            e = wr ? '0 : (ap ? ap_reg[a] : dp_reg[a]);
            run_cmd(ap, wr, 0, a, wd, 0);
            chk("R2/R3/R4/R5 random result", {got_st, got_d}, {2'd0, e});
            chk("R5 random xfers", got_n, exp_xfers(ap, wr) + nw);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule